// File: doc/BRIEF.md
# Event Packet Link Framer

This block sits on the front-end side of a gigabit serial link. It turns buffered event data into a stream of 16-bit link symbols, one symbol per clock, for the line encoder and serializer that follow it. Each symbol carries a two-bit type tag: idle, carrier-extend, data or error. Every level-1 trigger accept asks for one packet. A packet is one carrier-extend, then the event's words on back-to-back cycles, then a second carrier-extend. Every other cycle on the link is idle. No header or trailer code is used.

Event words enter through a valid/ready port with an end-of-event flag and an empty-event flag. They go into an internal buffer. A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when the buffer is full. The source must hold its word and flags stable until the word is taken. A packet starts only when an accept is pending and a complete event is in the buffer. After that it never stalls. Accepts that arrive early, or during a packet, are counted and served in arrival order.

An event must fit in the buffer. A zero-length event is a single beat with both `in_last` and `in_empty` set. The output side has no back-pressure: the serializer takes one symbol every cycle.

Top module: `evpkt_framer`

## Requirements
- R1: After reset, and whenever no packet is being sent, `sym_type` is idle (code 0) and `sym_data` is 0. After reset, `in_ready` is 1.
- R2: A packet opens with one carrier-extend symbol (code 1). The next cycle carries the event's first data word (code 2), with no idle between them.
- R3: The cycle right after the last data word of an event carries one carrier-extend symbol that closes the packet.
- R4: Data words leave on consecutive cycles, in the order they were accepted, with all 16 bits unchanged.
- R5: A packet begins only when a trigger accept is pending and the buffer holds a complete event, meaning a beat with `in_last` = 1 has been taken. Until then the output stays idle.
- R6: Each accept pulse produces exactly one packet. Up to 2^PEND_W-1 accepts can be outstanding, including accepts that arrive during a packet. They are served in order.
- R7: When packets are backlogged, exactly one idle symbol separates the closing carrier-extend of one packet from the opening carrier-extend of the next.
- R8: A beat with `in_last` = 1 and `in_empty` = 1 is a zero-length event. It produces two carrier-extend symbols on consecutive cycles, and its data field is not sent.
- R9: The error type (code 3) never appears on `sym_type`.
- R10: `in_ready` is 0 while the buffer holds DEPTH words. A word offered while `in_ready` is 0 is not taken and never appears on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_accept | input | 1 | One-cycle pulse per level-1 accepted event |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | WORD_W | Event word (12-bit payload plus 4-bit label, or 16 raw bits) |
| in_last | input | 1 | Beat ends the event |
| in_empty | input | 1 | With in_last: zero-length event marker, data ignored |
| sym_type | output | 2 | Symbol type: 0 idle, 1 carrier-extend, 2 data, 3 error |
| sym_data | output | WORD_W | Symbol payload, zero unless type is data |

## Verification
The bench builds the framer with DEPTH = 8 and PEND_W = 3. The small buffer lets one eight-word event fill it completely, so the loss of `in_ready` and the refusal of an extra word can be observed with a short test. The three-bit accept counter is large enough for a backlog of three packets sent back to back, which exercises the single-idle gap. A zero-length event sent between two normal events checks that the carrier-extend pairing stays aligned.

// File: rtl/evpkt_pkg.sv
package evpkt_pkg;
  typedef enum logic [1:0] {
    SYM_IDLE = 2'd0,
    SYM_CEXT = 2'd1,
    SYM_DATA = 2'd2,
    SYM_ERR  = 2'd3
  } sym_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_OPEN,
    TX_BODY,
    TX_CLOSE
  } tx_st_e;
endpackage

// File: rtl/evpkt_buf.sv
module evpkt_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              wr_empty,
  input  logic              pop,
  output logic [WORD_W-1:0] head_data,
  output logic              head_last,
  output logic              head_empty,
  output logic              evt_avail
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = WORD_W + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill, evt_cnt;
  logic          wr_fire, wr_eoe, rd_eoe;

  assign wr_ready  = (fill != CW'(DEPTH));
  assign wr_fire   = wr_valid && wr_ready;
  assign wr_eoe    = wr_last || wr_empty;
  assign head_data  = mem[rd_ptr][WORD_W-1:0];
  assign head_last  = mem[rd_ptr][WORD_W];
  assign head_empty = mem[rd_ptr][WORD_W+1];
  assign rd_eoe    = head_last || head_empty;
  assign evt_avail = (evt_cnt != '0);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= {wr_empty, wr_eoe, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      evt_cnt <= '0;
    end else begin
      if (wr_fire) wr_ptr <= step(wr_ptr);
      if (pop)     rd_ptr <= step(rd_ptr);
      fill    <= fill + CW'(wr_fire) - CW'(pop);
      evt_cnt <= evt_cnt + CW'(wr_fire && wr_eoe) - CW'(pop && rd_eoe);
    end
  end
endmodule

// File: rtl/evpkt_pend.sv
module evpkt_pend #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt,
  output logic              nonzero
);
  assign nonzero = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/evpkt_tx.sv
module evpkt_tx
  import evpkt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [WORD_W-1:0] head_data,
  input  logic              head_last,
  input  logic              head_empty,
  output logic              pop,
  output logic              start,
  output logic [1:0]        sym_type,
  output logic [WORD_W-1:0] sym_data
);
  tx_st_e            st, st_nx;
  logic              last_sent, last_nx;
  sym_e              type_nx;
  logic [WORD_W-1:0] data_nx;

  always_comb begin
    st_nx   = st;
    last_nx = last_sent;
    type_nx = SYM_IDLE;
    data_nx = '0;
    pop     = 1'b0;
    start   = 1'b0;
    unique case (st)
      TX_IDLE: if (start_ok) begin
        start   = 1'b1;
        type_nx = SYM_CEXT;
        st_nx   = TX_OPEN;
      end
      TX_OPEN: begin
        pop = 1'b1;
        if (head_empty) begin
          type_nx = SYM_CEXT;
          st_nx   = TX_CLOSE;
        end else begin
          type_nx = SYM_DATA;
          data_nx = head_data;
          last_nx = head_last;
          st_nx   = TX_BODY;
        end
      end
      TX_BODY: begin
        if (last_sent) begin
          type_nx = SYM_CEXT;
          st_nx   = TX_CLOSE;
        end else begin
          pop     = 1'b1;
          type_nx = SYM_DATA;
          data_nx = head_data;
          last_nx = head_last;
        end
      end
      TX_CLOSE: st_nx = TX_IDLE;
      default:  st_nx = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      last_sent <= 1'b0;
      sym_type  <= SYM_IDLE;
      sym_data  <= '0;
    end else begin
      st        <= st_nx;
      last_sent <= last_nx;
      sym_type  <= type_nx;
      sym_data  <= data_nx;
    end
  end
endmodule

// File: rtl/evpkt_framer.sv
module evpkt_framer #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_accept,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_empty,
  output logic [1:0]        sym_type,
  output logic [WORD_W-1:0] sym_data
);
  logic [WORD_W-1:0] head_data;
  logic              head_last, head_empty, evt_avail;
  logic              pop, pkt_start, pend_nz;
  logic [PEND_W-1:0] pend_cnt;

  evpkt_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(in_data),
    .wr_last(in_last), .wr_empty(in_empty),
    .pop(pop), .head_data(head_data), .head_last(head_last),
    .head_empty(head_empty), .evt_avail(evt_avail)
  );

  evpkt_pend #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .inc(trig_accept), .dec(pkt_start),
    .cnt(pend_cnt), .nonzero(pend_nz)
  );

  evpkt_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start_ok(pend_nz && evt_avail),
    .head_data(head_data), .head_last(head_last), .head_empty(head_empty),
    .pop(pop), .start(pkt_start),
    .sym_type(sym_type), .sym_data(sym_data)
  );
endmodule

// File: rtl/evpkt_framer_chk.sv
module evpkt_framer_chk #(
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_accept,
  input logic              pkt_start,
  input logic [PEND_W-1:0] pend_cnt,
  input logic [1:0]        sym_type
);
  logic in_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (sym_type == 2'd1) in_pkt <= !in_pkt;
  end

  AST_NO_ERR_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    sym_type != 2'd3); // R9

  AST_OPEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt && sym_type == 2'd1) |=> (sym_type == 2'd2 || sym_type == 2'd1)); // R2

  AST_BODY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_type == 2'd2) |=> (sym_type == 2'd2 || sym_type == 2'd1)); // R4

  AST_CLOSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && sym_type == 2'd1) |=> (sym_type == 2'd0)); // R7

  AST_NO_PEND_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_accept && !pkt_start && pend_cnt == {PEND_W{1'b1}})); // R6
endmodule

bind evpkt_framer evpkt_framer_chk #(.PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_accept(trig_accept),
  .pkt_start(pkt_start), .pend_cnt(pend_cnt), .sym_type(sym_type)
);

// File: tb/tb_evpkt_framer.sv
`timescale 1ns/1ps
module tb_evpkt_framer;
  localparam int W = 16;
  localparam int RN = 256;

  logic clk = 0, rst_n = 0, trig_accept = 0, in_valid = 0, in_last = 0, in_empty = 0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic [1:0] sym_type;
  logic [W-1:0] sym_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [1:0]   rec_t [RN];
  logic [W-1:0] rec_d [RN];
  int rn = 0;
  bit rec_on = 0;
  logic [1:0]   exp_t [64];
  logic [W-1:0] exp_d [64];
  int en = 0;

  evpkt_framer #(.WORD_W(W), .DEPTH(8), .PEND_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .trig_accept(trig_accept),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_empty(in_empty),
    .sym_type(sym_type), .sym_data(sym_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rec_on && rn < RN) begin
      rec_t[rn] = sym_type;
      rec_d[rn] = sym_data;
      rn++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [W-1:0] d, input bit last, input bit empty);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last; in_empty = empty;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0; in_last = 0; in_empty = 0;
  endtask

  task automatic trig();
    @(negedge clk); trig_accept = 1;
    @(negedge clk); trig_accept = 0;
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rec_start();
    rn = 0; rec_on = 1;
  endtask

  task automatic add(input logic [1:0] t, input logic [W-1:0] d);
    exp_t[en] = t; exp_d[en] = d; en++;
  endtask

  // compares recorded stream from the first non-idle symbol with exp, then all idle
  task automatic expect_seq(input string req);
    int f = -1;
    bit ok = 1;
    int act = 0, expv = 0;
    rec_on = 0;
    for (int i = 0; i < rn; i++) if (f < 0 && rec_t[i] != 2'd0) f = i;
    if (f < 0) begin
      chk(0, {req, " no packet seen"}, 0, 1);
      return;
    end
    for (int k = 0; k < en && ok; k++) begin
      if (f + k >= rn || rec_t[f+k] != exp_t[k] ||
          (exp_t[k] == 2'd2 && rec_d[f+k] != exp_d[k])) begin
        ok = 0;
        act = (f + k < rn) ? {rec_t[f+k], rec_d[f+k]} : 0;
        expv = {exp_t[k], exp_d[k]};
        $display("  at symbol %0d of sequence", k);
      end
    end
    for (int i = f + en; i < rn && ok; i++) begin
      if (rec_t[i] != 2'd0) begin
        ok = 0; act = rec_t[i]; expv = 0;
        $display("  trailing symbol %0d not idle", i - f);
      end
    end
    chk(ok, {req, " symbol sequence"}, act, expv);
    for (int i = 0; i < rn; i++) if (rec_t[i] == 2'd3) ok = 0;
    chk(ok, "R9 no error symbol", 3, 0);
    en = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sym_type == 2'd0, "R1 reset type idle", sym_type, 0);
    chk(sym_data == '0, "R1 reset data zero", sym_data, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    idle_cyc(5);
    chk(sym_type == 2'd0, "R1 idle with nothing pending", sym_type, 0);
  endtask

  task automatic t_single();
    rec_start();
    push(16'hA123, 0, 0); push(16'hFFFF, 0, 0);
    push(16'h0000, 0, 0); push(16'h5E01, 1, 0);
    idle_cyc(3);
    trig();
    idle_cyc(15);
    add(1, 0); add(2, 16'hA123); add(2, 16'hFFFF); add(2, 16'h0000); add(2, 16'h5E01); add(1, 0);
    expect_seq("R2 R3 R4 single event");
  endtask

  task automatic t_wait_data();
    bit all_idle = 1;
    rec_start();
    trig();
    push(16'h1111, 0, 0); push(16'h2222, 0, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sym_type != 2'd0) all_idle = 0;
    end
    chk(all_idle, "R5 idle while event incomplete", !all_idle, 0);
    push(16'h3333, 1, 0);
    idle_cyc(12);
    add(1, 0); add(2, 16'h1111); add(2, 16'h2222); add(2, 16'h3333); add(1, 0);
    expect_seq("R5 packet after event completes");
  endtask

  task automatic t_backlog();
    rec_start();
    push(16'hC001, 1, 0);
    push(16'hC002, 0, 0); push(16'hC003, 1, 0);
    push(16'hC004, 1, 0);
    @(negedge clk); trig_accept = 1;
    repeat (3) @(negedge clk);
    trig_accept = 0;
    idle_cyc(25);
    add(1, 0); add(2, 16'hC001); add(1, 0); add(0, 0);
    add(1, 0); add(2, 16'hC002); add(2, 16'hC003); add(1, 0); add(0, 0);
    add(1, 0); add(2, 16'hC004); add(1, 0);
    expect_seq("R6 R7 backlog of three");
  endtask

  task automatic t_empty_evt();
    rec_start();
    push(16'hDEAD, 1, 1);
    push(16'h7777, 1, 0);
    trig(); trig();
    idle_cyc(20);
    add(1, 0); add(1, 0); add(0, 0); add(1, 0); add(2, 16'h7777); add(1, 0);
    expect_seq("R8 zero-length event then normal");
  endtask

  task automatic t_full();
    for (int i = 0; i < 7; i++) push(16'hF000 + 16'(i), 0, 0);
    push(16'hF007, 1, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 ready low when full", in_ready, 0);
    in_valid = 1; in_data = 16'hBAD0; in_last = 1;
    idle_cyc(3);
    chk(in_ready == 1'b0, "R10 ready stays low", in_ready, 0);
    in_valid = 0; in_last = 0;
    rec_start();
    trig();
    idle_cyc(20);
    add(1, 0);
    for (int i = 0; i < 8; i++) add(2, 16'hF000 + 16'(i));
    add(1, 0);
    expect_seq("R10 refused word not sent");
    chk(in_ready == 1'b1, "R10 ready back after drain", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_wait_data();
    t_backlog();
    t_empty_evt();
    t_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule